// File: doc/BRIEF.md
# Timer clock prescaler and selector

This block produces count-enable pulses for three timers from one clock domain. An 8-bit control register selects how fast each timer advances. A shared prescaled tick is derived either from the system clock, at one of three fixed ratios, or from an external clock input. The external clock is first synchronized and edge-detected, then divided by eight. Timers 0 and 1 each choose between the shared tick and every system clock. Each of them can also be placed in counter mode, which silences its enable here because pin counting is handled elsewhere. Timer 2 has a low-byte choice and a high-byte choice. The high-byte choice matters only when that timer runs as two separate 8-bit halves.

Every output is a one-cycle enable in the system clock domain, never a derived clock. Selecting the raw system clock holds the enable high. The prescale logic is a four-state machine: PS_DIV12, PS_DIV4, PS_DIV48 and PS_EXT8. Reset enters PS_DIV12. A register write whose code field differs from the current state moves the machine to the state of that code and clears the internal counter. A write carrying the same code leaves the state and the count alone. No other transitions exist.

Register layout: bits 1:0 are the prescale code (00 every 12 clocks, 01 every 4, 10 every 48, 11 external divided by 8). Bit 2 bypasses Timer 0 to the system clock and bit 3 does the same for Timer 1. Bit 4 selects the system clock for the Timer 2 low byte and bit 5 for its high byte. Bits 7:6 are reserved.

Top module: `tmr_tick_gen`

## Requirements
- R1: Reset sets the register to 0x00. A write stores bits 5:0, and the next cycle the read port shows them, with bits 7:6 always read as 0.
- R2: With code 00, bit 2 clear and no counter mode, t0_en_o is high for one cycle every 12 clocks. After reset is released, the first pulse comes in the 12th cycle. t1_en_o behaves the same way with bit 3 clear.
- R3: Code 01 gives one pulse every 4 clocks and code 10 one pulse every 48 clocks. After the write, the first pulse comes that many cycles later.
- R4: With code 11, one pulse appears per 8 rising edges of ext_clk_i. The pulse appears two cycles after the edge is first sampled, behind a two-flop synchronizer.
- R5: A write that changes the code restarts the internal count. The first pulse in the new mode comes a full period after the write, regardless of the phase before.
- R6: Bit 2 set holds t0_en_o high, and bit 3 set holds t1_en_o high.
- R7: t0_cnt_mode_i or t1_cnt_mode_i high forces that timer's enable low, whatever the register holds.
- R8: Bit 4 set holds t2lo_en_o high. Otherwise t2lo_en_o follows a free-running every-12-clocks tick when t2_ext_sel_i is 0, and the external divide-by-8 tick when it is 1.
- R9: With t2_split_i high, bit 5 set holds t2hi_en_o high, and bit 5 clear gives it the same Timer 2 source as R8. With t2_split_i low, t2hi_en_o equals t2lo_en_o and bit 5 has no effect.
- R10: A prescaled enable never stays high for two consecutive cycles while the configuration is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Register read data |
| ext_clk_i | input | 1 | Asynchronous external clock |
| t0_cnt_mode_i | input | 1 | Timer 0 in counter mode |
| t1_cnt_mode_i | input | 1 | Timer 1 in counter mode |
| t2_split_i | input | 1 | Timer 2 split into two 8-bit halves |
| t2_ext_sel_i | input | 1 | Timer 2 non-bypass source: 0 every 12 clocks, 1 external/8 |
| t0_en_o | output | 1 | Timer 0 count enable |
| t1_en_o | output | 1 | Timer 1 count enable |
| t2lo_en_o | output | 1 | Timer 2 (low byte) count enable |
| t2hi_en_o | output | 1 | Timer 2 high byte count enable |

## Verification
The properties assume that the mode flags and t2_ext_sel_i change only between clock edges. They also assume that the external clock stays high and low for at least two system clocks each, so the edge detector never merges or misses edges. The stimulus changes inputs just after a rising edge and holds each external clock phase for two system clocks. The single-pulse property is conditioned on a stable code and bypass bit, because a reconfiguring write may legitimately join two different ticks.

// File: rtl/tmr_tick_pkg.sv
`timescale 1ns/1ps
package tmr_tick_pkg;
    // Prescale machine states; encoding equals the register code field
    typedef enum logic [1:0] {
        PS_DIV12 = 2'b00,
        PS_DIV4  = 2'b01,
        PS_DIV48 = 2'b10,
        PS_EXT8  = 2'b11
    } ps_state_e;
endpackage

// File: rtl/tmr_ext_sync.sv
`timescale 1ns/1ps
module tmr_ext_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ext_i,
    output logic edge_o
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-1:0], ext_i};
    end

    assign edge_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler
    import tmr_tick_pkg::*;
#(
    parameter int DIV_A   = 12,
    parameter int DIV_B   = 4,
    parameter int DIV_C   = 48,
    parameter int EXT_DIV = 8,
    parameter int FIX_DIV = 12
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       code_we_i,
    input  logic [1:0] code_i,
    input  logic       ext_edge_i,
    output logic [1:0] code_o,
    output logic       ps_tick_o,
    output logic       ext_tick_o,
    output logic       fix_tick_o
);
    localparam int MAX_AB = (DIV_A > DIV_B) ? DIV_A : DIV_B;
    localparam int MAX_D  = (MAX_AB > DIV_C) ? MAX_AB : DIV_C;
    localparam int CNT_W  = $clog2(MAX_D);
    localparam int EXT_W  = $clog2(EXT_DIV);
    localparam int FIX_W  = $clog2(FIX_DIV);

    ps_state_e          state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, last_val;
    logic [EXT_W-1:0]   ecnt_q;
    logic [FIX_W-1:0]   fcnt_q;
    logic               restart;

    assign state_d = ps_state_e'(code_i);
    assign restart = code_we_i && (state_d != state_q);

    // State register: any write loads the code; only a change restarts
    always_ff @(posedge clk_i) begin
        if (!rst_ni)        state_q <= PS_DIV12;
        else if (code_we_i) state_q <= state_d;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)                         cnt_q <= '0;
        else if (restart || cnt_q == last_val) cnt_q <= '0;
        else                                 cnt_q <= cnt_q + 1'b1;
    end

    // External divider advances only on detected edges
    always_ff @(posedge clk_i) begin
        if (!rst_ni) ecnt_q <= '0;
        else if (ext_edge_i) begin
            if (ecnt_q == EXT_W'(EXT_DIV - 1)) ecnt_q <= '0;
            else                               ecnt_q <= ecnt_q + 1'b1;
        end
    end

    // Free-running fixed divider for the timer 2 source
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                            fcnt_q <= '0;
        else if (fcnt_q == FIX_W'(FIX_DIV - 1)) fcnt_q <= '0;
        else                                    fcnt_q <= fcnt_q + 1'b1;
    end

    assign ext_tick_o = ext_edge_i && (ecnt_q == EXT_W'(EXT_DIV - 1));
    assign fix_tick_o = (fcnt_q == FIX_W'(FIX_DIV - 1));
    assign code_o     = state_q;

    // Output process: per-state period and tick source
    always_comb begin
        last_val  = CNT_W'(MAX_D - 1);
        ps_tick_o = 1'b0;
        unique case (state_q)
            PS_DIV12: begin
                last_val  = CNT_W'(DIV_A - 1);
                ps_tick_o = (cnt_q == CNT_W'(DIV_A - 1));
            end
            PS_DIV4: begin
                last_val  = CNT_W'(DIV_B - 1);
                ps_tick_o = (cnt_q == CNT_W'(DIV_B - 1));
            end
            PS_DIV48: begin
                last_val  = CNT_W'(DIV_C - 1);
                ps_tick_o = (cnt_q == CNT_W'(DIV_C - 1));
            end
            PS_EXT8: begin
                last_val  = CNT_W'(MAX_D - 1);
                ps_tick_o = ext_tick_o;
            end
        endcase
    end
endmodule

// File: rtl/tmr_tick_sel.sv
`timescale 1ns/1ps
module tmr_tick_sel #(
    parameter int N_TMR = 2
) (
    input  logic [N_TMR-1:0] cnt_mode_i,
    input  logic [N_TMR-1:0] sys_sel_i,
    input  logic             ps_tick_i,
    input  logic             t2_lo_sys_i,
    input  logic             t2_hi_sys_i,
    input  logic             t2_split_i,
    input  logic             t2_ext_sel_i,
    input  logic             ext_tick_i,
    input  logic             fix_tick_i,
    output logic [N_TMR-1:0] tmr_en_o,
    output logic             t2lo_en_o,
    output logic             t2hi_en_o
);
    logic t2_base;

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        assign tmr_en_o[g] = !cnt_mode_i[g] && (sys_sel_i[g] || ps_tick_i);
    end

    always_comb begin
        t2_base   = t2_ext_sel_i ? ext_tick_i : fix_tick_i;
        t2lo_en_o = t2_lo_sys_i || t2_base;
        if (t2_split_i) t2hi_en_o = t2_hi_sys_i || t2_base;
        else            t2hi_en_o = t2lo_en_o;
    end
endmodule

// File: rtl/tmr_tick_gen.sv
`timescale 1ns/1ps
module tmr_tick_gen #(
    parameter int DIV_A       = 12,
    parameter int DIV_B       = 4,
    parameter int DIV_C       = 48,
    parameter int EXT_DIV     = 8,
    parameter int FIX_DIV     = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       cfg_we_i,
    input  logic [7:0] cfg_wdata_i,
    output logic [7:0] cfg_rdata_o,
    input  logic       ext_clk_i,
    input  logic       t0_cnt_mode_i,
    input  logic       t1_cnt_mode_i,
    input  logic       t2_split_i,
    input  logic       t2_ext_sel_i,
    output logic       t0_en_o,
    output logic       t1_en_o,
    output logic       t2lo_en_o,
    output logic       t2hi_en_o
);
    // Upper six register bits; the top two are reserved and masked to zero
    localparam logic [5:0] HI_MASK = 6'b001111;

    logic [5:0] hi_q;
    logic [1:0] code;
    logic       ext_edge, ps_tick, ext_tick, fix_tick;
    logic [1:0] tmr_en;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)       hi_q <= '0;
        else if (cfg_we_i) hi_q <= cfg_wdata_i[7:2] & HI_MASK;
    end

    assign cfg_rdata_o = {hi_q, code};

    tmr_ext_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ext_i  (ext_clk_i),
        .edge_o (ext_edge)
    );

    tmr_prescaler #(
        .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C),
        .EXT_DIV(EXT_DIV), .FIX_DIV(FIX_DIV)
    ) i_pre (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .code_we_i  (cfg_we_i),
        .code_i     (cfg_wdata_i[1:0]),
        .ext_edge_i (ext_edge),
        .code_o     (code),
        .ps_tick_o  (ps_tick),
        .ext_tick_o (ext_tick),
        .fix_tick_o (fix_tick)
    );

    tmr_tick_sel #(.N_TMR(2)) i_sel (
        .cnt_mode_i   ({t1_cnt_mode_i, t0_cnt_mode_i}),
        .sys_sel_i    (hi_q[1:0]),
        .ps_tick_i    (ps_tick),
        .t2_lo_sys_i  (hi_q[2]),
        .t2_hi_sys_i  (hi_q[3]),
        .t2_split_i   (t2_split_i),
        .t2_ext_sel_i (t2_ext_sel_i),
        .ext_tick_i   (ext_tick),
        .fix_tick_i   (fix_tick),
        .tmr_en_o     (tmr_en),
        .t2lo_en_o    (t2lo_en_o),
        .t2hi_en_o    (t2hi_en_o)
    );

    assign t0_en_o = tmr_en[0];
    assign t1_en_o = tmr_en[1];
endmodule

// File: rtl/tmr_tick_gen_chk.sv
`timescale 1ns/1ps
module tmr_tick_gen_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       cfg_we_i,
    input logic [7:0] cfg_wdata_i,
    input logic [7:0] cfg_rdata_o,
    input logic       t0_cnt_mode_i,
    input logic       t1_cnt_mode_i,
    input logic       t2_split_i,
    input logic       t0_en_o,
    input logic       t1_en_o,
    input logic       t2lo_en_o,
    input logic       t2hi_en_o
);
    p_write_readback_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_we_i |=> cfg_rdata_o == {2'b00, $past(cfg_wdata_i[5:0])});

    p_reserved_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_rdata_o[7:6] == 2'b00);

    p_restart_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && cfg_wdata_i[1:0] != cfg_rdata_o[1:0] && cfg_wdata_i[1:0] != 2'b11
         && !cfg_wdata_i[2] && !t0_cnt_mode_i)
        |=> (!t0_en_o || t0_cnt_mode_i || cfg_rdata_o[2]));

    p_t0_bypass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!t0_cnt_mode_i && cfg_rdata_o[2]) |-> t0_en_o);

    p_t1_bypass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!t1_cnt_mode_i && cfg_rdata_o[3]) |-> t1_en_o);

    p_t0_cnt_mode_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        t0_cnt_mode_i |-> !t0_en_o);

    p_t1_cnt_mode_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        t1_cnt_mode_i |-> !t1_en_o);

    p_t2lo_bypass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_rdata_o[4] |-> t2lo_en_o);

    p_t2hi_mirror_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !t2_split_i |-> (t2hi_en_o == t2lo_en_o));

    p_t2hi_bypass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (t2_split_i && cfg_rdata_o[5]) |-> t2hi_en_o);

    p_single_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (t0_en_o && !cfg_rdata_o[2] && !t0_cnt_mode_i && !cfg_we_i)
        |=> (!t0_en_o || cfg_rdata_o[2] || t0_cnt_mode_i));
endmodule

bind tmr_tick_gen tmr_tick_gen_chk i_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_we_i      (cfg_we_i),
    .cfg_wdata_i   (cfg_wdata_i),
    .cfg_rdata_o   (cfg_rdata_o),
    .t0_cnt_mode_i (t0_cnt_mode_i),
    .t1_cnt_mode_i (t1_cnt_mode_i),
    .t2_split_i    (t2_split_i),
    .t0_en_o       (t0_en_o),
    .t1_en_o       (t1_en_o),
    .t2lo_en_o     (t2lo_en_o),
    .t2hi_en_o     (t2hi_en_o)
);

// File: tb/test_tmr_tick_gen.sv
`timescale 1ns/1ps
module test_tmr_tick_gen;
    localparam real CLK_PERIOD = 5.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       ext = 1'b0;
    logic       cm0 = 1'b0, cm1 = 1'b0, split = 1'b0, esel = 1'b0;
    logic       t0_en, t1_en, t2lo_en, t2hi_en;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int r0 = 0;
    bit done = 1'b0;

    typedef struct {
        int         cyc;
        int         sig;
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t q[$];
    item_t it;
    logic [7:0] act;

    always #(CLK_PERIOD / 2.0) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tmr_tick_gen i_tmr_tick_gen (
        .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
        .cfg_rdata_o(rdata), .ext_clk_i(ext), .t0_cnt_mode_i(cm0),
        .t1_cnt_mode_i(cm1), .t2_split_i(split), .t2_ext_sel_i(esel),
        .t0_en_o(t0_en), .t1_en_o(t1_en), .t2lo_en_o(t2lo_en), .t2hi_en_o(t2hi_en)
    );

    // Driver side: expected items, kept ordered by cycle
    function automatic void push(int c, int s, logic [7:0] e, string r);
        item_t n;
        int i;
        n.cyc = c; n.sig = s; n.exp = e; n.req = r;
        i = q.size();
        while (i > 0 && q[i-1].cyc > c) i--;
        q.insert(i, n);
    endfunction

    function automatic logic fix12(int c);
        return ((c - r0) % 12) == 11;
    endfunction

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [7:0] v);
        @(posedge clk); #1;
        we = 1'b1; wdata = v;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic expect_period(int w, int n, int span, int sig, string r);
        for (int k = 0; k < span; k++)
            push(w + k, sig, {7'd0, (k % n) == n - 1}, r);
    endtask

    // Monitor side: compare every item due in the current cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            it = q.pop_front();
            case (it.sig)
                0: act = {7'd0, t0_en};
                1: act = {7'd0, t1_en};
                2: act = {7'd0, t2lo_en};
                3: act = {7'd0, t2hi_en};
                default: act = rdata;
            endcase
            checks++;
            if (it.cyc != cyc || act !== it.exp) begin
                fails++;
                $display("FAIL %s sig=%0d cycle=%0d actual=%0h expected=%0h",
                         it.req, it.sig, it.cyc, act, it.exp);
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin : driver
        int w, w1, c;
        step(3);
        rst_n = 1'b1;
        r0 = cyc;
        // R1 reset value; R2 default divide-by-12 on both timers; R8 fixed T2 tick
        push(r0, 4, 8'h00, "R1");
        expect_period(r0, 12, 36, 0, "R2");
        expect_period(r0, 12, 36, 1, "R2");
        for (int k = 0; k < 36; k++) push(r0 + k, 2, {7'd0, fix12(r0 + k)}, "R8");
        step(36);

        // R3 divide-by-4 and divide-by-48
        wr(8'h01); w = cyc;
        push(w, 4, 8'h01, "R1");
        expect_period(w, 4, 16, 0, "R3");
        step(16);
        wr(8'h02); w = cyc;
        expect_period(w, 48, 100, 0, "R3");
        step(100);

        // R5 restart: switch code mid-period, first tick a full period after
        wr(8'h00); w1 = cyc;
        for (int k = 0; k < 7; k++) push(w1 + k, 0, 8'h00, "R5");
        step(5);
        wr(8'h01); w = cyc;
        expect_period(w, 4, 12, 0, "R5");
        step(12);

        // R1 reserved bits; R6 bypass; R8 low-byte bypass
        wr(8'hFF); w = cyc;
        push(w, 4, 8'h3F, "R1");
        for (int k = 0; k < 3; k++) begin
            push(w + k, 0, 8'h01, "R6");
            push(w + k, 1, 8'h01, "R6");
            push(w + k, 2, 8'h01, "R8");
        end
        step(3);

        // R7 counter mode overrides bypass
        cm0 = 1'b1; c = cyc;
        push(c, 0, 8'h00, "R7");
        push(c, 1, 8'h01, "R6");
        step(1);
        cm1 = 1'b1; c = cyc;
        push(c, 1, 8'h00, "R7");
        step(1);
        cm0 = 1'b0; cm1 = 1'b0;

        // R4 external divide-by-8 and R8 external source for T2
        wr(8'h03);
        esel = 1'b1;
        step(1);
        for (int i = 1; i <= 16; i++) begin
            c = cyc;
            ext = 1'b1;
            push(c,     0, 8'h00, "R4");
            push(c + 1, 0, 8'h00, "R4");
            push(c + 2, 0, {7'd0, (i % 8) == 0}, "R4");
            push(c + 3, 0, 8'h00, "R10");
            push(c + 2, 2, {7'd0, (i % 8) == 0}, "R8");
            step(2);
            ext = 1'b0;
            step(2);
        end
        esel = 1'b0;

        // R9 high byte: mirror when not split
        wr(8'h20); w = cyc;
        for (int k = 0; k < 24; k++) begin
            push(w + k, 2, {7'd0, fix12(w + k)}, "R8");
            push(w + k, 3, {7'd0, fix12(w + k)}, "R9");
        end
        step(24);
        // R9 split with high-byte bypass
        split = 1'b1; c = cyc;
        for (int k = 0; k < 24; k++) begin
            push(c + k, 3, 8'h01, "R9");
            push(c + k, 2, {7'd0, fix12(c + k)}, "R8");
        end
        step(24);
        // R9 split with low-byte bypass only
        wr(8'h10); w = cyc;
        for (int k = 0; k < 24; k++) begin
            push(w + k, 2, 8'h01, "R8");
            push(w + k, 3, {7'd0, fix12(w + k)}, "R9");
        end
        step(24);

        step(2);
        if (q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard actual=%0d expected=0 pending items", q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule